// File: doc/BRIEF.md
# 16-bit Instruction Execute Stage

This block is the execute stage of a single-issue core with a 16-bit instruction word and sixteen 32-bit general registers. It decodes one instruction per cycle and produces its register write-back (arithmetic, compare, add/shift-immediate, move and field-extract classes). For conditional branches it produces a taken flag and a target address instead of a write. The register file sits outside the block. The block drives two read indices from the instruction and takes the read data back in the same cycle. All results are registered and appear one clock after the instruction is presented.

A load issued earlier completes one slot late. The surrounding pipeline reports that pending load's destination register. When the instruction now executing writes that same register, the block flags that the late load data must be dropped. Undefined encodings raise an illegal flag and never write.

Top module: `rx16_exec`

## Requirements
- R1: The class is chosen by the first zero bit scanning down from bit 15: bit 15 = 0 arithmetic, else bit 14 = 0 compare, else bit 13 = 0 branch, else bit 12 = 0 add/shift-immediate, else special. Field positions: destination 11:8, first source 7:4, second source 3:0.
- R2: Arithmetic subcode (bits 14:12) 0..5 gives add, subtract (first minus second), and, or, xor, and a left shift of the first source by the full second-source value; counts of 32 or more give zero.
- R3: Arithmetic subcode 6 writes the zero-extended 8-bit immediate (bits 7:0). Subcode 7 writes the destination's old value shifted left 8 with the immediate in the low byte.
- R4: Compare (bit 13 = 0) writes 1 when first source < second source, else 0; signed when bit 12 = 1, unsigned otherwise. Bit 13 = 1 is illegal.
- R5: A branch is taken when (second source != 0) equals bit 12. Its target is PC plus the signed 8-bit offset in bits 11:4. A branch never writes a register.
- R6: Add/shift-immediate reads register (destination XOR 8·bit 7). With bit 6 = 0 it writes that value plus the signed 6-bit immediate in bits 5:0.
- R7: With bit 6 = 1 the add/shift-immediate result is a left shift by a non-negative immediate, or a logical right shift by the magnitude of a negative one (-32 gives zero).
- R8: A special op (bits 2:0) of 1 copies the first source. Ops 4 and 5 take the second source (index bits 3:0), shift it right by 8 × (first source bits 1:0), and keep 16 or 8 bits.
- R9: Special op 6 reads register (destination XOR 8·bit 3) and shifts it right by 8 × bits 7:6. It keeps 16 bits when bit 5 = 1, else 8 bits, and sign-extends from that width when bit 6 = 1.
- R10: Special op 7 raises the illegal flag with no write. Special ops 0, 2 and 3 neither write nor raise the flag.
- R11: When a load is pending and the current instruction writes its destination register, the drop flag is raised with that write; otherwise it stays low.
- R12: Outputs are registered one cycle after a valid instruction. With no valid instruction, and during reset, the write, branch, illegal and drop flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | PC_W | Address of the instruction |
| ra_idx_o | output | 4 | Read index, port A |
| ra_data_i | input | DATA_W | Register value at ra_idx_o |
| rb_idx_o | output | 4 | Read index, port B |
| rb_data_i | input | DATA_W | Register value at rb_idx_o |
| ld_pend_i | input | 1 | A delayed load completes in this slot |
| ld_dst_i | input | 4 | Destination register of that load |
| wb_en_o | output | 1 | Register write enable |
| wb_dst_o | output | 4 | Write destination |
| wb_data_o | output | DATA_W | Write data |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | PC_W | Branch target |
| illegal_o | output | 1 | Undefined encoding |
| ld_drop_o | output | 1 | Discard the delayed load data |

## Verification
Every result, flag and target is due exactly one clock after the instruction is presented. The bench drives an instruction on a falling edge. The rising edge captures it, and the bench compares all outputs on the next falling edge, before it drives the next instruction. The register file is a bench array answered combinationally from the read indices, so a wrong index shows up as wrong data at that same sample. Reset and idle cycles are sampled the same way, with every flag expected low.

// File: rtl/rx16_pkg.sv
package rx16_pkg;
  typedef enum logic [2:0] {
    CLS_ARITH,
    CLS_CMP,
    CLS_BR,
    CLS_ADDSH,
    CLS_SPEC
  } cls_e;

  localparam logic [2:0] SP_COPY = 3'd1;
  localparam logic [2:0] SP_X16  = 3'd4;
  localparam logic [2:0] SP_X8   = 3'd5;
  localparam logic [2:0] SP_FLD  = 3'd6;
  localparam logic [2:0] SP_BAD  = 3'd7;
endpackage

// File: rtl/rx16_decode.sv
module rx16_decode
  import rx16_pkg::*;
(
  input  logic [15:0] instr_i,
  output cls_e        cls_o,
  output logic [3:0]  rd_o,
  output logic [3:0]  ra_idx_o,
  output logic [3:0]  rb_idx_o,
  output logic        wr_o,
  output logic        illegal_o
);
  logic [2:0] op;
  assign op       = instr_i[2:0];
  assign rd_o     = instr_i[11:8];
  assign rb_idx_o = instr_i[3:0];

  always_comb begin
    casez (instr_i[15:12])
      4'b0???: cls_o = CLS_ARITH;
      4'b10??: cls_o = CLS_CMP;
      4'b110?: cls_o = CLS_BR;
      4'b1110: cls_o = CLS_ADDSH;
      default: cls_o = CLS_SPEC;
    endcase
  end

  always_comb begin
    ra_idx_o  = instr_i[7:4];
    wr_o      = 1'b0;
    illegal_o = 1'b0;
    unique case (cls_o)
      CLS_ARITH: begin
        wr_o = 1'b1;
        if (instr_i[14:12] == 3'd7) ra_idx_o = rd_o;
      end
      CLS_CMP: begin
        wr_o      = !instr_i[13];
        illegal_o = instr_i[13];
      end
      CLS_BR: ;
      CLS_ADDSH: begin
        wr_o     = 1'b1;
        ra_idx_o = rd_o ^ {instr_i[7], 3'b000};
      end
      CLS_SPEC: begin
        wr_o      = (op == SP_COPY) || (op == SP_X16) || (op == SP_X8) || (op == SP_FLD);
        illegal_o = (op == SP_BAD);
        if (op == SP_FLD) ra_idx_o = rd_o ^ {instr_i[3], 3'b000};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rx16_alu.sv
module rx16_alu
  import rx16_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cls_e              cls_i,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SH_LIM = DATA_W'(DATA_W);

  logic [DATA_W-1:0] arith_r, cmp_r, imm_r, simm_x;
  logic [5:0]        mag;
  logic              lt;
  logic              unused_alu;

  assign unused_alu = ^{instr_i[15], instr_i[11:8]};
  assign simm_x     = {{(DATA_W-6){instr_i[5]}}, instr_i[5:0]};
  assign mag        = ~instr_i[5:0] + 6'd1;

  always_comb begin
    unique case (instr_i[14:12])
      3'd0: arith_r = a_i + b_i;
      3'd1: arith_r = a_i - b_i;
      3'd2: arith_r = a_i & b_i;
      3'd3: arith_r = a_i | b_i;
      3'd4: arith_r = a_i ^ b_i;
      3'd5: arith_r = (b_i >= SH_LIM) ? '0 : (a_i << b_i[SH_W-1:0]);
      3'd6: arith_r = {{(DATA_W-8){1'b0}}, instr_i[7:0]};
      default: arith_r = {a_i[DATA_W-9:0], instr_i[7:0]};
    endcase
  end

  assign lt    = instr_i[12] ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
  assign cmp_r = {{(DATA_W-1){1'b0}}, lt};

  always_comb begin
    if (!instr_i[6])     imm_r = a_i + simm_x;
    else if (instr_i[5]) imm_r = a_i >> mag;
    else                 imm_r = a_i << instr_i[4:0];
  end

  always_comb begin
    unique case (cls_i)
      CLS_ARITH: res_o = arith_r;
      CLS_CMP:   res_o = cmp_r;
      CLS_ADDSH: res_o = imm_r;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/rx16_special.sv
module rx16_special
  import rx16_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] ext, fld;
  logic [2:0]        op;
  logic              unused_sp;

  assign unused_sp = ^{instr_i[15:8], instr_i[4:3]};
  assign op  = instr_i[2:0];
  assign ext = b_i >> {a_i[1:0], 3'b000};
  assign fld = a_i >> {instr_i[7:6], 3'b000};

  always_comb begin
    unique case (op)
      SP_COPY: res_o = a_i;
      SP_X16:  res_o = {{(DATA_W-16){1'b0}}, ext[15:0]};
      SP_X8:   res_o = {{(DATA_W-8){1'b0}}, ext[7:0]};
      SP_FLD: begin
        if (instr_i[5])
          res_o = {{(DATA_W-16){instr_i[6] & fld[15]}}, fld[15:0]};
        else
          res_o = {{(DATA_W-8){instr_i[6] & fld[7]}}, fld[7:0]};
      end
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/rx16_branch.sv
module rx16_branch #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16
) (
  input  logic [15:0]       instr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  logic unused_br;
  assign unused_br = ^{instr_i[15:13], instr_i[3:0]};

  assign taken_o  = ((|b_i) == instr_i[12]);
  assign target_o = pc_i + {{(PC_W-8){instr_i[11]}}, instr_i[11:4]};
endmodule

// File: rtl/rx16_exec.sv
module rx16_exec
  import rx16_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       instr_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [3:0]        ra_idx_o,
  input  logic [DATA_W-1:0] ra_data_i,
  output logic [3:0]        rb_idx_o,
  input  logic [DATA_W-1:0] rb_data_i,
  input  logic              ld_pend_i,
  input  logic [3:0]        ld_dst_i,
  output logic              wb_en_o,
  output logic [3:0]        wb_dst_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              br_taken_o,
  output logic [PC_W-1:0]   br_target_o,
  output logic              illegal_o,
  output logic              ld_drop_o
);
  cls_e              cls;
  logic [3:0]        rd;
  logic              wr, ill, taken;
  logic [DATA_W-1:0] alu_res, sp_res, res;
  logic [PC_W-1:0]   target;

  rx16_decode u_dec (
    .instr_i  (instr_i),
    .cls_o    (cls),
    .rd_o     (rd),
    .ra_idx_o (ra_idx_o),
    .rb_idx_o (rb_idx_o),
    .wr_o     (wr),
    .illegal_o(ill)
  );

  rx16_alu #(.DATA_W(DATA_W)) u_alu (
    .cls_i  (cls),
    .instr_i(instr_i),
    .a_i    (ra_data_i),
    .b_i    (rb_data_i),
    .res_o  (alu_res)
  );

  rx16_special #(.DATA_W(DATA_W)) u_sp (
    .instr_i(instr_i),
    .a_i    (ra_data_i),
    .b_i    (rb_data_i),
    .res_o  (sp_res)
  );

  rx16_branch #(.DATA_W(DATA_W), .PC_W(PC_W)) u_br (
    .instr_i (instr_i),
    .pc_i    (pc_i),
    .b_i     (rb_data_i),
    .taken_o (taken),
    .target_o(target)
  );

  assign res = (cls == CLS_SPEC) ? sp_res : alu_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o     <= 1'b0;
      wb_dst_o    <= '0;
      wb_data_o   <= '0;
      br_taken_o  <= 1'b0;
      br_target_o <= '0;
      illegal_o   <= 1'b0;
      ld_drop_o   <= 1'b0;
    end else begin
      wb_en_o     <= valid_i & wr;
      wb_dst_o    <= rd;
      wb_data_o   <= res;
      br_taken_o  <= valid_i & (cls == CLS_BR) & taken;
      br_target_o <= target;
      illegal_o   <= valid_i & ill;
      // late load loses to a same-slot write of its register
      ld_drop_o   <= valid_i & wr & ld_pend_i & (rd == ld_dst_i);
    end
  end
endmodule

// File: rtl/rx16_exec_chk.sv
module rx16_exec_chk #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [15:0]       instr_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [3:0]        ra_idx_o,
  input logic [DATA_W-1:0] ra_data_i,
  input logic [3:0]        rb_idx_o,
  input logic [DATA_W-1:0] rb_data_i,
  input logic              ld_pend_i,
  input logic [3:0]        ld_dst_i,
  input logic              wb_en_o,
  input logic [3:0]        wb_dst_o,
  input logic [DATA_W-1:0] wb_data_o,
  input logic              br_taken_o,
  input logic [PC_W-1:0]   br_target_o,
  input logic              illegal_o,
  input logic              ld_drop_o
);
  logic unused_chk;
  assign unused_chk = ^{pc_i, ra_idx_o, ra_data_i, rb_idx_o, rb_data_i, br_target_o, ld_pend_i};

  a_r5_branch_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[15:13] == 3'b110) |=> !wb_en_o && !illegal_o);

  a_r10_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o);

  a_r11_drop_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_drop_o |-> wb_en_o && (wb_dst_o == $past(ld_dst_i)));

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wb_en_o && !br_taken_o && !illegal_o && !ld_drop_o);

  a_r4_cmp_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[15:13] == 3'b100) |=> wb_en_o && (wb_data_o[DATA_W-1:1] == '0));

  a_r3_ldi_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (instr_i[15:12] == 4'b0110) |=>
      wb_en_o && (wb_data_o == {{(DATA_W-8){1'b0}}, $past(instr_i[7:0])}));

  a_r1_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wb_en_o, br_taken_o, illegal_o}));
endmodule

bind rx16_exec rx16_exec_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/rx16_exec_tb.sv
module rx16_exec_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [15:0] pc_i = '0;
  logic [3:0]  ra_idx_o, rb_idx_o;
  logic [31:0] ra_data_i, rb_data_i;
  logic        ld_pend_i = 1'b0;
  logic [3:0]  ld_dst_i = '0;
  logic        wb_en_o, br_taken_o, illegal_o, ld_drop_o;
  logic [3:0]  wb_dst_o;
  logic [31:0] wb_data_o;
  logic [15:0] br_target_o;

  logic [31:0] rf [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  assign ra_data_i = rf[ra_idx_o];
  assign rb_data_i = rf[rb_idx_o];

  rx16_exec u_dut (.*);

  function automatic void model(input logic [15:0] i, input logic [15:0] pc,
                                input logic lp, input logic [3:0] ld,
                                output logic en, output logic [31:0] dat,
                                output logic br, output logic [15:0] tgt,
                                output logic ill, output logic drop);
    logic [3:0]  d = i[11:8];
    logic [3:0]  a = i[7:4];
    logic [3:0]  b = i[3:0];
    logic [31:0] v;
    int s;
    en = 0; dat = 0; br = 0; ill = 0; drop = 0;
    tgt = pc + {{8{i[11]}}, i[11:4]};
    if (!i[15]) begin
      en = 1;
      case (i[14:12])
        3'd0: dat = rf[a] + rf[b];
        3'd1: dat = rf[a] - rf[b];
        3'd2: dat = rf[a] & rf[b];
        3'd3: dat = rf[a] | rf[b];
        3'd4: dat = rf[a] ^ rf[b];
        3'd5: dat = (rf[b] >= 32) ? 0 : rf[a] << rf[b];
        3'd6: dat = {24'd0, i[7:0]};
        default: dat = (rf[d] << 8) | {24'd0, i[7:0]};
      endcase
    end else if (!i[14]) begin
      if (i[13]) ill = 1;
      else begin
        en = 1;
        if (i[12]) dat = ($signed(rf[a]) < $signed(rf[b])) ? 1 : 0;
        else       dat = (rf[a] < rf[b]) ? 1 : 0;
      end
    end else if (!i[13]) begin
      br = ((rf[b] != 0) == i[12]);
    end else if (!i[12]) begin
      en = 1;
      v = rf[d ^ {i[7], 3'b000}];
      s = $signed(i[5:0]);
      if (!i[6])     dat = v + s;
      else if (s < 0) dat = v >> (-s);
      else           dat = v << s;
    end else begin
      case (i[2:0])
        3'd1: begin en = 1; dat = rf[a]; end
        3'd4: begin en = 1; dat = (rf[b] >> (8 * rf[a][1:0])) & 32'hFFFF; end
        3'd5: begin en = 1; dat = (rf[b] >> (8 * rf[a][1:0])) & 32'hFF; end
        3'd6: begin
          en = 1;
          v = rf[d ^ {i[3], 3'b000}] >> (8 * i[7:6]);
          if (i[5]) dat = i[6] ? {{16{v[15]}}, v[15:0]} : {16'd0, v[15:0]};
          else      dat = i[6] ? {{24{v[7]}}, v[7:0]} : {24'd0, v[7:0]};
        end
        3'd7: ill = 1;
        default: ;
      endcase
    end
    drop = lp && en && (d == ld);
  endfunction

  // drive on a falling edge, compare on the next falling edge
  task automatic issue(input string tag, input logic v, input logic [15:0] i,
                       input logic [15:0] pc, input logic lp, input logic [3:0] ld);
    logic en, br, ill, drop, ok;
    logic [31:0] dat;
    logic [15:0] tgt;
    model(i, pc, lp, ld, en, dat, br, tgt, ill, drop);
    if (!v) begin en = 0; br = 0; ill = 0; drop = 0; end
    valid_i = v; instr_i = i; pc_i = pc; ld_pend_i = lp; ld_dst_i = ld;
    @(posedge clk_i);
    @(negedge clk_i);
    ok = (wb_en_o == en) && (!en || (wb_dst_o == i[11:8] && wb_data_o == dat)) &&
         (br_taken_o == br) && (!br || br_target_o == tgt) &&
         (illegal_o == ill) && (ld_drop_o == drop);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s instr=%h: got en=%b dst=%h data=%h br=%b tgt=%h ill=%b drop=%b; exp en=%b dst=%h data=%h br=%b tgt=%h ill=%b drop=%b",
               tag, i, wb_en_o, wb_dst_o, wb_data_o, br_taken_o, br_target_o, illegal_o, ld_drop_o,
               en, i[11:8], dat, br, tgt, ill, drop);
    end
  endtask

  task automatic run(input string tag, input logic [15:0] i);
    issue(tag, 1'b1, i, 16'd100, 1'b0, 4'd0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) rf[k] = 32'h0101_0101 * k;
    rf[0] = 0; rf[1] = 5; rf[2] = 3; rf[3] = 32'hFFFF_FFFE; rf[4] = 32'h8000_0001;
    rf[5] = 32'h1234_5678; rf[6] = 40; rf[7] = 32'hDEAD_BEEF; rf[9] = 32'hA5C3_F081;
    rf[10] = 31; rf[13] = 32'h1122_3344; rf[15] = 32'h0000_8F00;
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (wb_en_o || br_taken_o || illegal_o || ld_drop_o || wb_data_o != 0) begin
      n_fail++;
      $display("FAIL R12 reset: got en=%b br=%b ill=%b drop=%b data=%h; exp all zero",
               wb_en_o, br_taken_o, illegal_o, ld_drop_o, wb_data_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 arithmetic
    run("R2 add", 16'h0152);
    run("R2 sub", 16'h1121);
    run("R2 and", 16'h2179);
    run("R2 or",  16'h3159);
    run("R2 xor", 16'h4197);
    run("R2 shl3", 16'h5152);
    run("R2 shl40", 16'h5156);
    run("R2 shl31", 16'h514A);
    // R3 immediates; R1 bit15 low wins over ones below
    run("R3 ldi", 16'h63A5);
    run("R3 shin", 16'h759C);
    run("R1 prio", 16'h7FFF);
    // R4 compare
    run("R4 ult", 16'h8131);
    run("R4 slt", 16'h9131);
    run("R4 ult2", 16'h8113);
    run("R4 eq", 16'h9155);
    run("R4 undef", 16'hA131);
    // R5 branch
    issue("R5 zero taken", 1'b1, 16'hCF00, 16'd100, 1'b1, 4'hF);
    run("R5 zero not", 16'hCF01);
    run("R5 nz taken", 16'hD7F1);
    run("R5 nz not", 16'hD7F0);
    // R6 add imm, R7 shift imm
    run("R6 add", 16'hE103);
    run("R6 bank", 16'hE1BF);
    run("R7 shl", 16'hE544);
    run("R7 shr", 16'hE57C);
    run("R7 shr32", 16'hE560);
    run("R7 bank", 16'hE7C1);
    // R8 move / extract
    run("R8 copy", 16'hF171);
    run("R8 x16", 16'hF124);
    run("R8 x8", 16'hF11D);
    // R9 field
    run("R9 s16", 16'hF566);
    run("R9 s8bank", 16'hF74E);
    run("R9 u8", 16'hF786);
    run("R9 u16", 16'hF726);
    run("R9 s8hi", 16'hF7C6);
    // R10 illegal / no-write specials
    run("R10 op7", 16'hF107);
    run("R10 op0", 16'hF100);
    run("R10 op2", 16'hF102);
    run("R10 op3", 16'hF103);
    // R11 load drop
    issue("R11 same", 1'b1, 16'h0152, 16'd0, 1'b1, 4'd1);
    issue("R11 other", 1'b1, 16'h0152, 16'd0, 1'b1, 4'd2);
    issue("R11 nopend", 1'b1, 16'h0152, 16'd0, 1'b0, 4'd1);
    issue("R11 branch", 1'b1, 16'hC100, 16'd0, 1'b1, 4'd1);
    // R12 idle
    issue("R12 idle", 1'b0, 16'h0152, 16'd0, 1'b1, 4'd1);
    issue("R12 idle2", 1'b0, 16'hF107, 16'd0, 1'b0, 4'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got running, exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule